// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

A single programmable timer channel for a peripheral subsystem. A 32-bit counter steps down once per timebase tick; when a tick arrives with the counter already at zero, the counter takes the reload constant instead of wrapping, a sticky underflow flag is raised, and a level interrupt is asserted when the underflow interrupt enable is set. The timebase is either a binary prescaler that counts pulses of a clock-enable input, or synchronised edges of an external clock pin.

Software reaches four word registers through a simple one-cycle bus: reload constant (word 0), live count (word 1), control (word 2) and an optional capture holding register (word 3). A separate start level from an outside start register runs or pauses the channel. Writing a control value that uses a reserved or unsupported encoding raises a sticky error output; each illegal field keeps its previous value while the legal fields of the same write take effect. Two parameters select whether the external-clock and capture features exist.

Top module: `tmr_channel`

## Requirements
- R1: After reset the reload and count registers read 0xFFFFFFFF, control and capture read 0, irq and cfg_err are low.
- R2: While run_en is low the count does not change, whatever tick_en does.
- R3: Control bits 2:0 pick the internal divisor: 0→4, 1→16, 2→64, 3→256, 4→1024 tick_en pulses per count step; the prescaler clears when run_en rises, so the first step lands one full divisor after the start edge.
- R4: A step taken with the count at zero loads the reload value and sets the underflow flag, read at control bit 8.
- R5: irq equals the underflow flag AND control bit 5.
- R6: A control write with bit 8 at 0 clears the underflow flag; with bit 8 at 1 the flag is left as it was.
- R7: Any control write while running stalls the timebase for that cycle and clears the prescaler, so the next step comes one full divisor after the write.
- R8: The internal prescaler advances only in cycles where tick_en is high.
- R9: With the external clock present, divisor codes 6 and 7 step the counter on synchronised ext_clk edges chosen by control bits 4:3: 0 rising, 1 falling, 2 or 3 both.
- R10: A control write with divisor code 5, a nonzero capture-mode code 1 (bits 7:6), or any of bits 15:10 set, sets cfg_err until reset; each illegal field keeps its old value, the other fields are written, and bit 9 always reads 0.
- R11: With capture present, word 3 is a read/write 32-bit register.
- R12: Writes to word 0 and word 1 load the reload value and the count; a count write takes priority over a step in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Start level from the outside start register |
| tick_en | input | 1 | Clock-enable pulse counted by the prescaler |
| ext_clk | input | 1 | External clock pin, asynchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 2 | Register word number |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq | output | 1 | Underflow interrupt level |
| cfg_err | output | 1 | Sticky illegal-configuration indication |

## Verification
A prescaler phase error shows at the count register within one divisor period, so the bench reads the count at the last cycle before an expected step and at the step itself. A wrong underflow flag or enable shows at irq and control bit 8 on the same edge as the reload, and a field that accepted an illegal code shows in the next control read and at cfg_err right after the write. The edge detector is checked by counting count decrements over a known number of ext_clk pulses per edge mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int REG_W  = 32;
    localparam int CTRL_W = 16;
    localparam int PRE_W  = 10;

    typedef enum logic [1:0] {
        REG_RELOAD = 2'd0,
        REG_COUNT  = 2'd1,
        REG_CTRL   = 2'd2,
        REG_CAPT   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       cap_flag;
        logic       uf_flag;
        logic [1:0] cap_mode;
        logic       uf_ie;
        logic [1:0] edge_sel;
        logic [2:0] div_sel;
    } ctrl_t;

    // Last prescaler phase before a step for an internal divisor code.
    function automatic logic [PRE_W-1:0] presc_last(input logic [2:0] sel);
        int unsigned span;
        span = 32'd4 << (2 * int'(sel));
        return PRE_W'(span - 32'd1);
    endfunction

    function automatic logic is_ext(input logic [2:0] sel);
        return sel[2] & sel[1];
    endfunction

    function automatic logic div_ok(input logic [2:0] sel, input logic ext_ok);
        return (sel <= 3'd4) || (is_ext(sel) && ext_ok);
    endfunction

    function automatic logic edge_ok(input logic [1:0] e, input logic ext_ok);
        return (e == 2'd0) || ext_ok;
    endfunction

    function automatic logic capm_ok(input logic [1:0] m, input logic cap_ok);
        return (m == 2'd0) || (m[1] && cap_ok);
    endfunction

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    logic [SYNC_STAGES:0] shift_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= {shift_q[SYNC_STAGES-1:0], din};
    end

    assign rise = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
    assign fall = ~shift_q[SYNC_STAGES-1] & shift_q[SYNC_STAGES];

    always_comb begin
        unique case (edge_sel)
            2'd0:    hit = rise;
            2'd1:    hit = fall;
            default: hit = rise | fall;
        endcase
    end

    // R9: an edge is reported in one cycle only
    a_r9_single_hit: assert property (@(posedge clk) disable iff (rst)
        (hit && edge_sel == 2'd0) |=> !rise);
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc
    import tmr_pkg::*;
#(
    parameter int HAS_EXT = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clr,
    input  logic       tick_en,
    input  logic [2:0] div_sel,
    input  logic [1:0] edge_sel,
    input  logic       ext_clk,
    output logic       tick
);
    logic [PRE_W-1:0] pcnt_q;
    logic [PRE_W-1:0] last;
    logic ext_mode, int_hit, ext_hit;

    assign last     = presc_last(div_sel);
    assign ext_mode = (HAS_EXT != 0) && is_ext(div_sel);
    assign int_hit  = tick_en && (pcnt_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pcnt_q <= '0;
        end else if (run && tick_en && !ext_mode) begin
            pcnt_q <= (pcnt_q == last) ? '0 : pcnt_q + 1'b1;
        end
    end

    generate
        if (HAS_EXT != 0) begin : g_ext
            tmr_edge_det #(.SYNC_STAGES(2)) u_edge (
                .clk      (clk),
                .rst      (rst),
                .din      (ext_clk),
                .edge_sel (edge_sel),
                .hit      (ext_hit)
            );
        end else begin : g_no_ext
            assign ext_hit = 1'b0;
        end
    endgenerate

    assign tick = run && !clr && (ext_mode ? ext_hit : int_hit);

    // R3: internal divisors are at least four, steps never come back to back
    a_r3_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && !ext_mode) |=> !tick);
    // R8: no internal step without a tick_en pulse
    a_r8_gated: assert property (@(posedge clk) disable iff (rst)
        (tick && !ext_mode) |-> tick_en);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic         rld_wr,
    input  logic [W-1:0] wdata,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic [W-1:0] rld,
    output logic         flag
);
    logic at_zero;
    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '1;
            rld  <= '1;
            flag <= 1'b0;
        end else begin
            if (rld_wr) rld <= wdata;
            if (cnt_wr)      cnt <= wdata;
            else if (tick)   cnt <= at_zero ? rld : cnt - 1'b1;
            if (tick && at_zero) flag <= 1'b1;
            else if (flag_clr)   flag <= 1'b0;
        end
    end

    // R2: a stopped channel holds its count
    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt));
    // R4: underflow step reloads
    a_r4_reload: assert property (@(posedge clk) disable iff (rst)
        (tick && at_zero && !cnt_wr) |=> (cnt == $past(rld)));
    // R4: flag rises only while running
    a_r4_flag_run: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(run));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int HAS_CAP = 1,
    parameter int HAS_EXT = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic             tick_en,
    input  logic             ext_clk,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    output logic             irq,
    output logic             cfg_err
);
    localparam logic EXT_OK = (HAS_EXT != 0);
    localparam logic CAP_OK = (HAS_CAP != 0);

    reg_sel_e   sel;
    ctrl_t      wctrl, rctrl;
    logic       wr, ctrl_wr, cnt_wr, rld_wr, cap_wr;
    logic       run_q, start, tick, flag;
    logic       f_div, f_edge, f_capm, f_rsvd, f_capf, bad_wr;
    logic [2:0] div_q;
    logic [1:0] edge_q, capm_q;
    logic       ie_q;
    logic [REG_W-1:0] cnt, rld, cap_q;

    assign sel     = reg_sel_e'(bus_addr);
    assign wctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign wr      = bus_sel && bus_we;
    assign ctrl_wr = wr && (sel == REG_CTRL);
    assign cnt_wr  = wr && (sel == REG_COUNT);
    assign rld_wr  = wr && (sel == REG_RELOAD);
    assign cap_wr  = wr && (sel == REG_CAPT);
    assign start   = run_en && !run_q;

    assign f_div  = div_ok(wctrl.div_sel, EXT_OK);
    assign f_edge = edge_ok(wctrl.edge_sel, EXT_OK);
    assign f_capm = capm_ok(wctrl.cap_mode, CAP_OK);
    assign f_rsvd = (wctrl.rsvd == '0);
    assign f_capf = !wctrl.cap_flag || CAP_OK;
    assign bad_wr = (ctrl_wr && !(f_div && f_edge && f_capm && f_rsvd && f_capf))
                 || (cap_wr && !CAP_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            div_q   <= '0;
            edge_q  <= '0;
            capm_q  <= '0;
            ie_q    <= 1'b0;
            cfg_err <= 1'b0;
        end else begin
            run_q <= run_en;
            if (bad_wr) cfg_err <= 1'b1;
            if (ctrl_wr) begin
                ie_q <= wctrl.uf_ie;
                if (f_div)  div_q  <= wctrl.div_sel;
                if (f_edge) edge_q <= wctrl.edge_sel;
                if (f_capm) capm_q <= wctrl.cap_mode;
            end
        end
    end

    tmr_presc #(.HAS_EXT(HAS_EXT)) u_presc (
        .clk      (clk),
        .rst      (rst),
        .run      (run_en),
        .clr      (ctrl_wr || start),
        .tick_en  (tick_en),
        .div_sel  (div_q),
        .edge_sel (edge_q),
        .ext_clk  (ext_clk),
        .tick     (tick)
    );

    tmr_count #(.W(REG_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .run      (run_en),
        .tick     (tick),
        .cnt_wr   (cnt_wr),
        .rld_wr   (rld_wr),
        .wdata    (bus_wdata),
        .flag_clr (ctrl_wr && !wctrl.uf_flag),
        .cnt      (cnt),
        .rld      (rld),
        .flag     (flag)
    );

    generate
        if (HAS_CAP != 0) begin : g_cap
            always_ff @(posedge clk) begin
                if (rst)         cap_q <= '0;
                else if (cap_wr) cap_q <= bus_wdata;
            end
        end else begin : g_no_cap
            assign cap_q = '0;
        end
    endgenerate

    always_comb begin
        rctrl          = '0;
        rctrl.div_sel  = div_q;
        rctrl.edge_sel = edge_q;
        rctrl.uf_ie    = ie_q;
        rctrl.cap_mode = capm_q;
        rctrl.uf_flag  = flag;
        bus_rdata      = '0;
        if (bus_sel) begin
            unique case (sel)
                REG_RELOAD: bus_rdata = rld;
                REG_COUNT:  bus_rdata = cnt;
                REG_CTRL:   bus_rdata = {{(REG_W-CTRL_W){1'b0}}, rctrl};
                default:    bus_rdata = cap_q;
            endcase
        end
    end

    assign irq = flag && ie_q;

    // R6: writing zero to the flag bit clears it
    a_r6_flag_clear: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wctrl.uf_flag) |=> !flag);
    // R7: the timebase is stalled in the cycle of a control write
    a_r7_pause: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |-> !tick);
    // R10: the error indication is sticky
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);
    // R10: a stored divisor code is always a legal one
    a_r10_div_legal: assert property (@(posedge clk) disable iff (rst)
        div_ok(div_q, EXT_OK));
endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run_en = 1'b0;
    logic        tick_en = 1'b1;
    logic        ext_clk = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, cfg_err;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tmr_channel i_tmr_channel (
        .clk(clk), .rst(rst), .run_en(run_en), .tick_en(tick_en),
        .ext_clk(ext_clk), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .cfg_err(cfg_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; run_en = 1'b0; tick_en = 1'b1; ext_clk = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic stop_run();
        @(negedge clk);
        run_en = 1'b0;
        @(posedge clk);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd_reg(2'd0, v); check("R1 reload", v, 32'hFFFF_FFFF);
        rd_reg(2'd1, v); check("R1 count", v, 32'hFFFF_FFFF);
        rd_reg(2'd2, v); check("R1 ctrl", v, 32'h0);
        rd_reg(2'd3, v); check("R1 capture", v, 32'h0);
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 err", 32'(cfg_err), 32'h0);
    endtask

    task automatic t_stopped();
        logic [31:0] v;
        do_reset();
        repeat (50) @(posedge clk);
        rd_reg(2'd1, v); check("R2 stopped count", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd0, 32'd5);
        wr_reg(2'd1, 32'd2);
        wr_reg(2'd2, 32'h20);
        @(negedge clk) run_en = 1'b1;
        repeat (12) @(posedge clk);
        rd_reg(2'd1, v); check("R4 count before underflow", v, 32'd0);
        check("R5 irq before underflow", 32'(irq), 32'h0);
        @(posedge clk);
        rd_reg(2'd1, v); check("R4 reload on underflow", v, 32'd5);
        check("R5 irq after underflow", 32'(irq), 32'h1);
        rd_reg(2'd2, v); check("R4 flag bit", v, 32'h120);
        stop_run();
        wr_reg(2'd2, 32'h100);
        check("R5 irq masked", 32'(irq), 32'h0);
        rd_reg(2'd2, v); check("R6 flag kept by one", v, 32'h100);
        wr_reg(2'd2, 32'h120);
        check("R5 irq unmasked", 32'(irq), 32'h1);
        wr_reg(2'd2, 32'h020);
        check("R6 irq after clear", 32'(irq), 32'h0);
        rd_reg(2'd2, v); check("R6 flag cleared by zero", v, 32'h020);
    endtask

    task automatic t_divisors();
        logic [31:0] v;
        for (int s = 0; s < 5; s++) begin
            int d;
            d = 4 << (2 * s);
            do_reset();
            wr_reg(2'd1, 32'd1000);
            wr_reg(2'd2, 32'(s));
            @(negedge clk) run_en = 1'b1;
            repeat (2 * d) @(posedge clk);
            rd_reg(2'd1, v); check($sformatf("R3 div code %0d before step", s), v, 32'd999);
            @(posedge clk);
            rd_reg(2'd1, v); check($sformatf("R3 div code %0d at step", s), v, 32'd998);
            stop_run();
        end
    endtask

    task automatic t_ctrl_restart();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd1, 32'd100);
        @(negedge clk) run_en = 1'b1;
        repeat (6) @(posedge clk);
        wr_reg(2'd2, 32'h0);
        repeat (3) @(posedge clk);
        rd_reg(2'd1, v); check("R7 no step two cycles after write", v, 32'd99);
        @(posedge clk);
        rd_reg(2'd1, v); check("R7 step one period after write", v, 32'd98);
        stop_run();
    endtask

    task automatic t_tick_gate();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd1, 32'd50);
        @(negedge clk) begin tick_en = 1'b0; run_en = 1'b1; end
        repeat (40) @(posedge clk);
        rd_reg(2'd1, v); check("R8 frozen without tick_en", v, 32'd50);
        @(negedge clk) tick_en = 1'b1;
        repeat (4) @(posedge clk);
        rd_reg(2'd1, v); check("R8 step after four tick_en", v, 32'd49);
        stop_run();
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ext_clk = 1'b1;
            repeat (5) @(posedge clk);
            @(negedge clk) ext_clk = 1'b0;
            repeat (5) @(posedge clk);
        end
    endtask

    task automatic t_ext_clock();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd1, 32'd20);
        wr_reg(2'd2, 32'h6);
        @(negedge clk) run_en = 1'b1;
        ext_pulses(3);
        rd_reg(2'd1, v); check("R9 rising edges", v, 32'd17);
        wr_reg(2'd2, 32'h0E);
        ext_pulses(2);
        rd_reg(2'd1, v); check("R9 falling edges", v, 32'd15);
        wr_reg(2'd2, 32'h16);
        ext_pulses(1);
        rd_reg(2'd1, v); check("R9 both edges", v, 32'd13);
        stop_run();
    endtask

    task automatic t_errors();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd2, 32'h25);
        check("R10 err on divisor 5", 32'(cfg_err), 32'h1);
        rd_reg(2'd2, v); check("R10 divisor kept, enable taken", v, 32'h20);
        do_reset();
        wr_reg(2'd2, 32'h200);
        check("R10 capture flag bit legal", 32'(cfg_err), 32'h0);
        rd_reg(2'd2, v); check("R10 bit 9 not stored", v, 32'h0);
        wr_reg(2'd2, 32'h440);
        check("R10 err on reserved bits", 32'(cfg_err), 32'h1);
        rd_reg(2'd2, v); check("R10 capture mode 1 refused", v, 32'h0);
        wr_reg(2'd2, 32'h80);
        check("R10 err sticky", 32'(cfg_err), 32'h1);
        rd_reg(2'd2, v); check("R10 capture mode 2 taken", v, 32'h80);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        do_reset();
        wr_reg(2'd3, 32'hCAFE_1234);
        rd_reg(2'd3, v); check("R11 capture register", v, 32'hCAFE_1234);
        wr_reg(2'd0, 32'h1357_9BDF);
        rd_reg(2'd0, v); check("R12 reload write", v, 32'h1357_9BDF);
        wr_reg(2'd1, 32'd500);
        @(negedge clk) run_en = 1'b1;
        repeat (9) @(posedge clk);
        wr_reg(2'd1, 32'd77);
        rd_reg(2'd1, v); check("R12 count write while running", v, 32'd77);
        stop_run();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset_state();
        t_stopped();
        t_underflow();
        t_divisors();
        t_ctrl_restart();
        t_tick_gate();
        t_ext_clock();
        t_errors();
        t_regs();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule